// File: doc/BRIEF.md
# USB Link Status Tracker

This block follows the state of a USB 2.0 link as seen by a high-speed signal conditioner. It turns digitized line events into two status flags. The connect flag `cd_flag` reports that a device is attached. The high-speed flag `hs_enable` switches on the high-speed compensation path. The analog front end supplies single-cycle event strobes and level signals: pull-up seen, disconnect, bus reset, chirp J and chirp K levels, squelch, test-fixture seen and test-packet seen. A free-running microsecond strobe `us_tick` is the time base for every duration the block measures.

High speed is granted only after a timed handshake. The sequence is a bus reset, then one chirp J and one chirp K whose lengths both fall inside a tick window, then squelch. Any chirp that is too short or too long leaves the link at low/full speed. A low pulse on `enable_in` that lasts long enough puts the block into shutdown. Releasing it after high-speed operation brings the link up in compliance test mode. A configuration hold input freezes the tracker at its unconnected state until it clears.

Top module: `hs_link_tracker`

## Requirements
- R1: After `rst_n` is released, with no events applied, `cd_flag` and `hs_enable` are both 0.
- R2: In the unconnected state, an `ev_pullup` strobe gives `cd_flag`=1 and `hs_enable`=0 (low/full-speed attach) from the next clock edge.
- R3: An `ev_disconnect` strobe in any state with `cd_flag`=1 returns the block to unconnected, with both flags 0 from the next edge.
- R4: From low/full-speed attach, the following sequence sets both flags to 1: `ev_bus_reset`, then `chirp_j` high for N ticks, then `chirp_k` high for M ticks (K may follow J with no gap), then `ev_squelch`. N and M must each lie in CHIRP_MIN_US..CHIRP_MAX_US inclusive (default 18..128). Before the squelch strobe, `hs_enable` stays 0.
- R5: A chirp J or K shorter than CHIRP_MIN_US ticks or longer than CHIRP_MAX_US ticks aborts the handshake. The block stays at low/full-speed attach (`cd_flag`=1, `hs_enable`=0), and a later `ev_squelch` has no effect.
- R6: In the unconnected state, `ev_fixture` followed by `ev_test_packet` enters compliance test mode, with `cd_flag`=0 and `hs_enable`=1.
- R7: Holding `enable_in` low on RST_MIN_US ticks in a row (default 100) forces shutdown, with both flags 0. A low pulse covering fewer ticks leaves the flags unchanged.
- R8: When `enable_in` returns high, shutdown ends in compliance test mode (`cd_flag`=0, `hs_enable`=1) if shutdown was entered from high-speed operation. From any other state it ends in the unconnected state.
- R9: While `cfg_hold` is 1, the block is held at the unconnected state with both flags 0 and all line events are ignored. Once it clears, tracking restarts from the unconnected state.
- R10: Chirp durations count `us_tick` strobes, not clock cycles. The duration counter saturates above CHIRP_MAX_US instead of wrapping, so a very long chirp (for example 300 ticks) still aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| enable_in | input | 1 | Device enable; a long enough low pulse means shutdown |
| cfg_hold | input | 1 | Halts tracking at the unconnected state while 1 |
| ev_pullup | input | 1 | Line pull-up detected strobe |
| ev_disconnect | input | 1 | Disconnect detected strobe |
| ev_bus_reset | input | 1 | Bus reset detected strobe |
| chirp_j | input | 1 | Chirp J level present |
| chirp_k | input | 1 | Chirp K level present |
| ev_squelch | input | 1 | Squelch detected strobe |
| ev_fixture | input | 1 | High-speed test fixture detected strobe |
| ev_test_packet | input | 1 | Test packet pattern seen strobe |
| cd_flag | output | 1 | Device connected flag |
| hs_enable | output | 1 | High-speed compensation enable flag |

## Verification
Both flags decode directly from the state register, so a wrong state shows on the ports at the clock edge right after the faulty transition. The one exception is a wrong state among the handshake steps: all of them show `cd_flag`=1 and `hs_enable`=0, so such an error only becomes visible when squelch arrives or fails to raise `hs_enable`. A chirp counter fault shows up the same way, at the squelch that follows. A wrong shutdown-origin memory stays hidden until `enable_in` is released. The directed scenarios therefore always finish each handshake or shutdown with the event that exposes it.

// File: rtl/hslt_pkg.sv
package hslt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,   // unconnected
        ST_FIX   = 4'd1,   // test fixture seen, awaiting test packet
        ST_LFS   = 4'd2,   // low/full-speed attach
        ST_BRST  = 4'd3,   // bus reset seen, awaiting chirp J
        ST_CHJ   = 4'd4,   // measuring chirp J
        ST_KWAIT = 4'd5,   // valid J done, awaiting chirp K
        ST_CHK   = 4'd6,   // measuring chirp K
        ST_HSARM = 4'd7,   // handshake passed, awaiting squelch
        ST_HS    = 4'd8,   // high-speed operation
        ST_COMP  = 4'd9,   // compliance test mode
        ST_OFF   = 4'd10   // shutdown
    } link_st_e;

    typedef struct packed {
        link_st_e st;
        logic     from_hs;   // shutdown was entered from high-speed operation
    } core_regs_t;

endpackage

// File: rtl/hslt_off_filter.sv
module hslt_off_filter #(
    parameter int MIN_LOW_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic enable_in,
    output logic off_valid
);
    localparam int RW = $clog2(MIN_LOW_TICKS + 1);
    localparam logic [RW-1:0] LIM = RW'(MIN_LOW_TICKS);

    logic [RW-1:0] low_cnt_d, low_cnt_q;

    always_comb begin
        if (enable_in) begin
            low_cnt_d = '0;
        end else if (us_tick && low_cnt_q != LIM) begin
            low_cnt_d = low_cnt_q + RW'(1);
        end else begin
            low_cnt_d = low_cnt_q;
        end
        off_valid = !enable_in && (low_cnt_d >= LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_cnt_q <= '0;
        else        low_cnt_q <= low_cnt_d;
    end
endmodule

// File: rtl/hslt_dur_timer.sv
module hslt_dur_timer #(
    parameter int MIN_TICKS = 18,
    parameter int MAX_TICKS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic start,
    input  logic hold,
    output logic in_win,
    output logic too_long
);
    localparam int CAP = MAX_TICKS + 1;
    localparam int CW  = $clog2(CAP + 1);
    localparam logic [CW-1:0] CAP_V = CW'(CAP);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_TICKS);
    localparam logic [CW-1:0] MAX_V = CW'(MAX_TICKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start) begin
            cnt_d = us_tick ? CW'(1) : '0;
        end else if (hold) begin
            cnt_d = (us_tick && cnt_q != CAP_V) ? cnt_q + CW'(1) : cnt_q;
        end else begin
            cnt_d = '0;
        end
        in_win   = (cnt_q >= MIN_V) && (cnt_q <= MAX_V);
        too_long = (cnt_q == CAP_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hslt_state_core.sv
module hslt_state_core
    import hslt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     off_valid,
    input  logic     cfg_hold,
    input  logic     ev_pullup,
    input  logic     ev_disconnect,
    input  logic     ev_bus_reset,
    input  logic     chirp_j,
    input  logic     chirp_k,
    input  logic     ev_squelch,
    input  logic     ev_fixture,
    input  logic     ev_test_packet,
    input  logic     in_win,
    input  logic     too_long,
    output logic     tmr_start,
    output logic     tmr_hold,
    output link_st_e cur_state
);
    core_regs_t r_d, r_q;
    logic attached;

    always_comb begin
        r_d = r_q;
        tmr_hold  = (r_q.st == ST_CHJ && chirp_j) || (r_q.st == ST_CHK && chirp_k);
        tmr_start = (r_q.st == ST_BRST && chirp_j)
                 || (r_q.st == ST_CHJ && !chirp_j && chirp_k)
                 || (r_q.st == ST_KWAIT && chirp_k);
        attached  = (r_q.st == ST_LFS)  || (r_q.st == ST_BRST)  || (r_q.st == ST_CHJ)
                 || (r_q.st == ST_KWAIT) || (r_q.st == ST_CHK) || (r_q.st == ST_HSARM)
                 || (r_q.st == ST_HS);

        if (off_valid) begin
            r_d.st = ST_OFF;
            if (r_q.st != ST_OFF) r_d.from_hs = (r_q.st == ST_HS);
        end else if (cfg_hold) begin
            r_d.st      = ST_IDLE;
            r_d.from_hs = 1'b0;
        end else if (attached && ev_disconnect) begin
            r_d.st = ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_OFF: begin
                    r_d.st      = r_q.from_hs ? ST_COMP : ST_IDLE;
                    r_d.from_hs = 1'b0;
                end
                ST_IDLE: begin
                    if (ev_pullup)       r_d.st = ST_LFS;
                    else if (ev_fixture) r_d.st = ST_FIX;
                end
                ST_FIX: begin
                    if (ev_test_packet)  r_d.st = ST_COMP;
                    else if (ev_pullup)  r_d.st = ST_LFS;
                end
                ST_COMP: begin
                    if (ev_disconnect)   r_d.st = ST_IDLE;
                end
                ST_LFS: begin
                    if (ev_bus_reset)    r_d.st = ST_BRST;
                end
                ST_BRST: begin
                    if (chirp_j)         r_d.st = ST_CHJ;
                end
                ST_CHJ: begin
                    if (too_long)        r_d.st = ST_LFS;
                    else if (!chirp_j) begin
                        if (!in_win)     r_d.st = ST_LFS;
                        else if (chirp_k) r_d.st = ST_CHK;
                        else             r_d.st = ST_KWAIT;
                    end
                end
                ST_KWAIT: begin
                    if (chirp_j)         r_d.st = ST_LFS;
                    else if (chirp_k)    r_d.st = ST_CHK;
                end
                ST_CHK: begin
                    if (too_long)        r_d.st = ST_LFS;
                    else if (!chirp_k)   r_d.st = in_win ? ST_HSARM : ST_LFS;
                end
                ST_HSARM: begin
                    if (ev_squelch)        r_d.st = ST_HS;
                    else if (ev_bus_reset) r_d.st = ST_BRST;
                end
                ST_HS: begin
                    if (ev_bus_reset)    r_d.st = ST_BRST;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.from_hs <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cur_state = r_q.st;
endmodule

// File: rtl/hslt_flag_decode.sv
module hslt_flag_decode
    import hslt_pkg::*;
(
    input  link_st_e state,
    output logic     cd_flag,
    output logic     hs_enable
);
    always_comb begin
        cd_flag   = 1'b0;
        hs_enable = 1'b0;
        case (state)
            ST_LFS, ST_BRST, ST_CHJ, ST_KWAIT, ST_CHK, ST_HSARM: cd_flag = 1'b1;
            ST_HS: begin
                cd_flag   = 1'b1;
                hs_enable = 1'b1;
            end
            ST_COMP: hs_enable = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/hs_link_tracker.sv
module hs_link_tracker
    import hslt_pkg::*;
#(
    parameter int RST_MIN_US   = 100,
    parameter int CHIRP_MIN_US = 18,
    parameter int CHIRP_MAX_US = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic enable_in,
    input  logic cfg_hold,
    input  logic ev_pullup,
    input  logic ev_disconnect,
    input  logic ev_bus_reset,
    input  logic chirp_j,
    input  logic chirp_k,
    input  logic ev_squelch,
    input  logic ev_fixture,
    input  logic ev_test_packet,
    output logic cd_flag,
    output logic hs_enable
);
    logic     off_valid;
    logic     in_win;
    logic     too_long;
    logic     tmr_start;
    logic     tmr_hold;
    link_st_e cur_state;

    hslt_off_filter #(.MIN_LOW_TICKS(RST_MIN_US)) u_off (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .enable_in (enable_in),
        .off_valid (off_valid)
    );

    hslt_dur_timer #(.MIN_TICKS(CHIRP_MIN_US), .MAX_TICKS(CHIRP_MAX_US)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .us_tick  (us_tick),
        .start    (tmr_start),
        .hold     (tmr_hold),
        .in_win   (in_win),
        .too_long (too_long)
    );

    hslt_state_core u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .off_valid      (off_valid),
        .cfg_hold       (cfg_hold),
        .ev_pullup      (ev_pullup),
        .ev_disconnect  (ev_disconnect),
        .ev_bus_reset   (ev_bus_reset),
        .chirp_j        (chirp_j),
        .chirp_k        (chirp_k),
        .ev_squelch     (ev_squelch),
        .ev_fixture     (ev_fixture),
        .ev_test_packet (ev_test_packet),
        .in_win         (in_win),
        .too_long       (too_long),
        .tmr_start      (tmr_start),
        .tmr_hold       (tmr_hold),
        .cur_state      (cur_state)
    );

    hslt_flag_decode u_dec (
        .state     (cur_state),
        .cd_flag   (cd_flag),
        .hs_enable (hs_enable)
    );
endmodule

// File: rtl/hslt_checker.sv
module hslt_checker
    import hslt_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     cfg_hold,
    input logic     ev_pullup,
    input logic     ev_disconnect,
    input logic     ev_squelch,
    input logic     ev_test_packet,
    input logic     off_valid,
    input logic     too_long,
    input link_st_e cur_state,
    input logic     cd_flag,
    input logic     hs_enable
);
    // R2: connect flag only rises on a pull-up strobe
    assert_cd_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cd_flag) |-> $past(ev_pullup));

    // R3: disconnect while connected clears the connect flag
    assert_disconnect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_disconnect && cd_flag) |=> !cd_flag);

    // R4 / R6 / R8: high-speed flag rises only on squelch, test packet or shutdown exit
    assert_hs_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_enable) |-> $past(ev_squelch || ev_test_packet || cur_state == ST_OFF));

    // R5: an overlong chirp leaves the link at low/full-speed attach
    assert_chirp_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (too_long && !ev_disconnect && !off_valid && !cfg_hold) |=> (cd_flag && !hs_enable));

    // R7: a qualified shutdown drops both flags
    assert_shutdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        off_valid |=> (!cd_flag && !hs_enable));

    // R9: configuration hold keeps both flags low
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hold |=> (!cd_flag && !hs_enable));
endmodule

bind hs_link_tracker hslt_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_hold       (cfg_hold),
    .ev_pullup      (ev_pullup),
    .ev_disconnect  (ev_disconnect),
    .ev_squelch     (ev_squelch),
    .ev_test_packet (ev_test_packet),
    .off_valid      (off_valid),
    .too_long       (too_long),
    .cur_state      (cur_state),
    .cd_flag        (cd_flag),
    .hs_enable      (hs_enable)
);

// File: tb/test_hs_link_tracker.sv
module test_hs_link_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b1;
    logic enable_in = 1'b1;
    logic cfg_hold = 1'b0;
    logic ev_pullup = 1'b0, ev_disconnect = 1'b0, ev_bus_reset = 1'b0;
    logic chirp_j = 1'b0, chirp_k = 1'b0, ev_squelch = 1'b0;
    logic ev_fixture = 1'b0, ev_test_packet = 1'b0;
    logic cd_flag, hs_enable;
    logic half_rate = 1'b0;
    int   n_tests = 0;
    int   n_fail = 0;
    int   cycles = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    hs_link_tracker i_hs_link_tracker (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .enable_in(enable_in),
        .cfg_hold(cfg_hold), .ev_pullup(ev_pullup), .ev_disconnect(ev_disconnect),
        .ev_bus_reset(ev_bus_reset), .chirp_j(chirp_j), .chirp_k(chirp_k),
        .ev_squelch(ev_squelch), .ev_fixture(ev_fixture), .ev_test_packet(ev_test_packet),
        .cd_flag(cd_flag), .hs_enable(hs_enable)
    );

    always @(negedge clk) us_tick <= half_rate ? ~us_tick : 1'b1;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic exp_cd, input logic exp_hs);
        n_tests++;
        if (cd_flag !== exp_cd || hs_enable !== exp_hs) begin
            n_fail++;
            $display("FAIL %s: cd=%b hs=%b expected cd=%b hs=%b",
                     req, cd_flag, hs_enable, exp_cd, exp_hs);
        end
    endtask

    // 0 pullup, 1 disconnect, 2 bus reset, 3 squelch, 4 fixture, 5 test packet
    task automatic pulse(input int which);
        case (which)
            0: ev_pullup = 1'b1;
            1: ev_disconnect = 1'b1;
            2: ev_bus_reset = 1'b1;
            3: ev_squelch = 1'b1;
            4: ev_fixture = 1'b1;
            default: ev_test_packet = 1'b1;
        endcase
        @(negedge clk);
        ev_pullup = 1'b0; ev_disconnect = 1'b0; ev_bus_reset = 1'b0;
        ev_squelch = 1'b0; ev_fixture = 1'b0; ev_test_packet = 1'b0;
    endtask

    task automatic handshake(input int jlen, input int klen);
        pulse(0);
        pulse(2);
        chirp_j = 1'b1;
        repeat (jlen) @(negedge clk);
        chirp_j = 1'b0;
        chirp_k = 1'b1;
        repeat (klen) @(negedge clk);
        chirp_k = 1'b0;
        @(negedge clk);
    endtask

    task automatic power_off(input int len);
        enable_in = 1'b0;
        repeat (len) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 reset state", 1'b0, 1'b0);
    endtask

    task automatic t_lfs_attach;
        pulse(0);
        chk("R2 pull-up attach", 1'b1, 1'b0);
        pulse(1);
        chk("R3 disconnect from attach", 1'b0, 1'b0);
    endtask

    task automatic t_hs_good(input int jlen, input int klen);
        handshake(jlen, klen);
        chk("R4 no hs before squelch", 1'b1, 1'b0);
        pulse(3);
        chk("R4 hs after handshake and squelch", 1'b1, 1'b1);
        pulse(1);
        chk("R3 disconnect from hs", 1'b0, 1'b0);
    endtask

    task automatic t_hs_bad(input string req, input int jlen, input int klen);
        handshake(jlen, klen);
        pulse(3);
        chk(req, 1'b1, 1'b0);
        pulse(1);
    endtask

    task automatic t_tick_rate;
        half_rate = 1'b1;
        t_hs_bad("R10 30 cycles is 15 ticks, too short", 30, 40);
        handshake(60, 60);
        pulse(3);
        chk("R10 60 cycles is 30 ticks, valid", 1'b1, 1'b1);
        pulse(1);
        half_rate = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_fixture;
        pulse(4);
        chk("R6 fixture alone stays unconnected", 1'b0, 0);
        pulse(5);
        chk("R6 compliance after test packet", 1'b0, 1'b1);
        pulse(1);
        chk("R3 disconnect from compliance", 1'b0, 1'b0);
    endtask

    task automatic t_shutdown;
        handshake(40, 40);
        pulse(3);
        power_off(99);
        enable_in = 1'b1;
        @(negedge clk);
        chk("R7 short low pulse ignored", 1'b1, 1'b1);
        power_off(120);
        chk("R7 shutdown flags low", 1'b0, 1'b0);
        enable_in = 1'b1;
        @(negedge clk);
        chk("R8 release after hs gives compliance", 1'b0, 1'b1);
        power_off(110);
        enable_in = 1'b1;
        @(negedge clk);
        chk("R8 release after compliance gives unconnected", 1'b0, 1'b0);
        pulse(0);
        power_off(100);
        chk("R7 exactly minimum low time", 1'b0, 1'b0);
        enable_in = 1'b1;
        @(negedge clk);
        chk("R8 release after attach gives unconnected", 1'b0, 1'b0);
    endtask

    task automatic t_hold;
        pulse(0);
        cfg_hold = 1'b1;
        @(negedge clk);
        chk("R9 hold forces unconnected", 1'b0, 1'b0);
        pulse(0);
        pulse(4);
        pulse(5);
        chk("R9 events ignored during hold", 1'b0, 1'b0);
        cfg_hold = 1'b0;
        @(negedge clk);
        chk("R9 restart from unconnected", 1'b0, 1'b0);
        pulse(0);
        chk("R9 attach after hold release", 1'b1, 1'b0);
        pulse(1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lfs_attach();
        t_hs_good(18, 128);
        t_hs_good(128, 18);
        t_hs_bad("R5 chirp J of 17 ticks aborts", 17, 20);
        t_hs_bad("R5 chirp K of 129 ticks aborts", 20, 129);
        t_hs_bad("R5 chirp K of 17 ticks aborts", 20, 17);
        t_hs_bad("R10 chirp J of 300 ticks saturates and aborts", 300, 20);
        t_tick_rate();
        t_fixture();
        t_shutdown();
        t_hold();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule